// File: doc/BRIEF.md
# Four-Phase Bundled-Data Channel Controller

This block links two pipeline stages, such as a branch-metric stage and an add-compare-select stage, through a single-rail channel. The channel has one wire for each data bit, a request wire and an acknowledge wire. The sender controller receives a one-cycle "word ready" pulse and loads the word into its output register. It waits a programmable number of cycles so that the bundle has settled, then raises request. The receiver controller sees request through a two-flop synchronizer. It captures the bundle, raises acknowledge on the next cycle, and lowers acknowledge once request has returned low. The sender sees acknowledge through its own two-flop synchronizer.

Every transfer goes through all four level phases:

1. The data is valid and request rises.
2. Acknowledge rises.
3. Request falls.
4. Acknowledge falls.

A new word cannot start until phase 4 has finished. A ready pulse that arrives during a transfer is held and launched afterwards.

Top module: `bd4_channel`

## Requirements
- R1: After a synchronous active-low reset, `link_req`, `link_ack`, `recv_strobe` and `send_busy` are all low.
- R2: `link_req` rises exactly `BUNDLE_DLY` cycles (default 2) after the clock edge that samples `send_go` and loads `link_data`. At that moment `link_data` equals the `send_word` presented with the pulse.
- R3: While `link_req` is high, `link_data` does not change.
- R4: The receiver copies `link_data` into `recv_word` and pulses `recv_strobe` for one cycle when its synchronized request reads high. `link_ack` rises exactly one cycle after that strobe.
- R5: The sender lowers `link_req` exactly 3 cycles after `link_ack` rises. This is two synchronizer flops plus one state update.
- R6: The receiver lowers `link_ack` exactly 3 cycles after `link_req` falls.
- R7: `link_req` never rises while `link_ack` is high. A new transfer begins only after acknowledge has returned low.
- R8: A `send_go` pulse sampled while a transfer is in progress is held pending and sent after the current transfer ends. If a second pulse arrives while one is already pending, the newer word replaces the held word.
- R9: `send_busy` is high from the cycle after `send_go` is sampled until the transfer and any pending word have finished.
- R10: Every launched word is delivered once, in launch order, with no loss when `send_go` arrives close to the end of a previous transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| send_go | input | 1 | One-cycle pulse: `send_word` is ready to transfer |
| send_word | input | WIDTH | Word to send |
| send_busy | output | 1 | Sender has a transfer in progress or a word pending |
| recv_word | output | WIDTH | Last word captured by the receiver |
| recv_strobe | output | 1 | One-cycle pulse: `recv_word` holds a new word |
| link_req | output | 1 | Channel request wire |
| link_ack | output | 1 | Channel acknowledge wire |
| link_data | output | WIDTH | Channel data bundle |

## Verification
Two events can fall in the same cycle: the sender finishes the return-to-zero phase, and a new ready pulse arrives. The sender must then either hold the pulse as pending or launch it directly, and it must never drop it or start it in the middle of a phase. The bench provokes this by watching `link_ack` fall and then issuing a pulse at each of several offsets after it, so that one offset lands exactly on the cycle the sender returns to idle. Each case is judged at the receiver: both words must arrive once and in order. A separate check confirms that request never rose while acknowledge was high.

// File: rtl/bd4_pkg.sv
// Package: shared state encodings for the bundled-data channel controllers.
// Assumes: nothing beyond SystemVerilog enums.
package bd4_pkg;

    typedef enum logic [1:0] {
        SND_IDLE   = 2'd0,
        SND_SETTLE = 2'd1,
        SND_REQ    = 2'd2,
        SND_RTZ    = 2'd3
    } snd_state_t;

    typedef enum logic [1:0] {
        RCV_IDLE = 2'd0,
        RCV_ACK  = 2'd1,
        RCV_HOLD = 2'd2
    } rcv_state_t;

endpackage

// File: rtl/bd4_sync.sv
// Module: multi-flop level synchronizer for a handshake wire.
// Assumes: STAGES >= 2; the input is a level that stays put for longer than STAGES cycles.
module bd4_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    // Shift the level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[LAST-1:0], d};
    end

    assign q = chain_q[LAST];

endmodule

// File: rtl/bd4_sender.sv
// Module: sender side of the four-phase channel.
// Loads a word when a ready pulse arrives (or a word is pending). Raises request
// BUNDLE_DLY cycles later, drops it once the synchronized acknowledge reads high,
// and goes back to idle once that acknowledge reads low again.
// Assumes: BUNDLE_DLY >= 1; ack_s is already synchronized to clk.
module bd4_sender
    import bd4_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int BUNDLE_DLY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [WIDTH-1:0] word,
    input  logic             ack_s,
    output logic             req,
    output logic [WIDTH-1:0] data,
    output logic             busy
);
    localparam int CW = $clog2(BUNDLE_DLY + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(BUNDLE_DLY - 1);
    localparam logic [CW-1:0] AGE_SAT  = CW'(BUNDLE_DLY);

    snd_state_t       state_q;
    logic [CW-1:0]    cnt_q;
    logic [WIDTH-1:0] data_q;
    logic             req_q;
    logic             pend_q;
    logic [WIDTH-1:0] pend_word_q;
    logic             start;
    logic             hold_go;

    // A new transfer starts from idle when a word is pending or a pulse arrives.
    assign start   = (state_q == SND_IDLE) && (pend_q || go);
    // A pulse is held if the sender is mid-transfer or already owes a word.
    assign hold_go = go && ((state_q != SND_IDLE) || pend_q);

    // Phase sequencing: settle, request high, wait for return-to-zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SND_IDLE;
            cnt_q   <= '0;
            req_q   <= 1'b0;
        end else begin
            unique case (state_q)
                SND_IDLE: begin
                    if (start) begin
                        cnt_q   <= '0;
                        state_q <= SND_SETTLE;
                    end
                end
                SND_SETTLE: begin
                    if (cnt_q == CNT_LAST) begin
                        req_q   <= 1'b1;
                        state_q <= SND_REQ;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SND_REQ: begin
                    if (ack_s) begin
                        req_q   <= 1'b0;
                        state_q <= SND_RTZ;
                    end
                end
                SND_RTZ: begin
                    if (!ack_s) state_q <= SND_IDLE;
                end
                default: state_q <= SND_IDLE;
            endcase
        end
    end

    // Data bundle register: loaded only when a transfer starts.
    always_ff @(posedge clk) begin
        if (!rst_n)     data_q <= '0;
        else if (start) data_q <= pend_q ? pend_word_q : word;
    end

    // Pending slot: the latest held word wins; cleared when it is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_word_q <= '0;
        end else if (hold_go) begin
            pend_q      <= 1'b1;
            pend_word_q <= word;
        end else if (start && pend_q) begin
            pend_q <= 1'b0;
        end
    end

    assign req  = req_q;
    assign data = data_q;
    assign busy = (state_q != SND_IDLE) || pend_q;

    // Checker state: cycles since the data register was last loaded, saturating.
    logic [CW-1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              age_q <= AGE_SAT;
        else if (start)          age_q <= '0;
        else if (age_q != AGE_SAT) age_q <= age_q + 1'b1;
    end

    // R2: request rises only once the bundle has aged the full matching delay.
    p_req_after_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> (age_q == AGE_SAT));

    // R3: bundle is frozen while request stays high.
    p_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && $past(req_q)) |-> $stable(data_q));

    // R5: request is withdrawn only after acknowledge was seen high.
    p_req_fall_on_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_q) |-> $past(ack_s));

endmodule

// File: rtl/bd4_receiver.sv
// Module: receiver side of the four-phase channel.
// Captures the bundle when the synchronized request reads high, raises acknowledge
// one cycle later, and drops acknowledge once the synchronized request reads low.
// Assumes: req_s is already synchronized to clk; the bundle is stable while request is high.
module bd4_receiver
    import bd4_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_s,
    input  logic [WIDTH-1:0] data,
    output logic             ack,
    output logic [WIDTH-1:0] word,
    output logic             strobe
);
    rcv_state_t       state_q;
    logic             ack_q;
    logic             strobe_q;
    logic [WIDTH-1:0] word_q;

    // Handshake sequencing: capture, acknowledge, wait for request to return low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RCV_IDLE;
            ack_q    <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            unique case (state_q)
                RCV_IDLE: begin
                    if (req_s) begin
                        strobe_q <= 1'b1;
                        state_q  <= RCV_ACK;
                    end
                end
                RCV_ACK: begin
                    ack_q   <= 1'b1;
                    state_q <= RCV_HOLD;
                end
                RCV_HOLD: begin
                    if (!req_s) begin
                        ack_q   <= 1'b0;
                        state_q <= RCV_IDLE;
                    end
                end
                default: state_q <= RCV_IDLE;
            endcase
        end
    end

    // Capture register for the received word.
    always_ff @(posedge clk) begin
        if (!rst_n)                            word_q <= '0;
        else if (state_q == RCV_IDLE && req_s) word_q <= data;
    end

    assign ack    = ack_q;
    assign word   = word_q;
    assign strobe = strobe_q;

    // R4: acknowledge rises only in the cycle right after a capture strobe.
    p_ack_after_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> $past(strobe_q));

    // R6: acknowledge is withdrawn only after request was seen low.
    p_ack_fall_on_req_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_q) |-> !$past(req_s));

endmodule

// File: rtl/bd4_channel.sv
// Module: four-phase bundled-data channel, sender and receiver joined by the link wires.
// Each handshake wire crosses through a SYNC_STAGES-flop synchronizer on the far side.
// Assumes: single clock in this model; BUNDLE_DLY >= 1; SYNC_STAGES >= 2.
module bd4_channel #(
    parameter int WIDTH       = 8,
    parameter int BUNDLE_DLY  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             send_go,
    input  logic [WIDTH-1:0] send_word,
    output logic             send_busy,
    output logic [WIDTH-1:0] recv_word,
    output logic             recv_strobe,
    output logic             link_req,
    output logic             link_ack,
    output logic [WIDTH-1:0] link_data
);
    logic req_w;
    logic ack_w;
    logic req_s;
    logic ack_s;
    logic [WIDTH-1:0] data_w;

    bd4_sender #(.WIDTH(WIDTH), .BUNDLE_DLY(BUNDLE_DLY)) u_snd (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (send_go),
        .word (send_word),
        .ack_s(ack_s),
        .req  (req_w),
        .data (data_w),
        .busy (send_busy)
    );

    bd4_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d(req_w), .q(req_s)
    );

    bd4_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_w), .q(ack_s)
    );

    bd4_receiver #(.WIDTH(WIDTH)) u_rcv (
        .clk   (clk),
        .rst_n (rst_n),
        .req_s (req_s),
        .data  (data_w),
        .ack   (ack_w),
        .word  (recv_word),
        .strobe(recv_strobe)
    );

    assign link_req  = req_w;
    assign link_ack  = ack_w;
    assign link_data = data_w;

    // R7: a new request never rises while acknowledge is still high.
    p_req_rise_ack_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_req) |-> !link_ack);

endmodule

// File: tb/sim_bd4_channel.sv
module sim_bd4_channel;
    localparam int W   = 8;
    localparam int DLY = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         send_go = 1'b0;
    logic [W-1:0] send_word = '0;
    logic         send_busy, recv_strobe, link_req, link_ack;
    logic [W-1:0] recv_word, link_data;

    int checks = 0;
    int fails  = 0;
    int r3_bad = 0;
    int r7_bad = 0;
    logic [W-1:0] rx [0:63];
    int rx_n = 0;
    logic [W-1:0] prev_data = '0;
    logic         prev_req = 1'b0;
    logic         prev_ack = 1'b0;

    always #5 clk = ~clk;

    bd4_channel #(.WIDTH(W), .BUNDLE_DLY(DLY), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .send_go(send_go), .send_word(send_word),
        .send_busy(send_busy), .recv_word(recv_word), .recv_strobe(recv_strobe),
        .link_req(link_req), .link_ack(link_ack), .link_data(link_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Monitors, sampled on the falling edge: log received words, watch for
    // R3 (data moves while request high) and R7 (request rises while ack high).
    always @(negedge clk) begin
        if (rst_n) begin
            if (recv_strobe && rx_n < 64) begin
                rx[rx_n] = recv_word;
                rx_n++;
            end
            if (prev_req && link_req && link_data != prev_data) r3_bad++;
            if (!prev_req && link_req && prev_ack) r7_bad++;
        end
        prev_req  = link_req;
        prev_ack  = link_ack;
        prev_data = link_data;
    end

    task automatic pulse(input logic [W-1:0] w);
        send_word = w;
        send_go   = 1'b1;
        @(negedge clk);
        send_go   = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (send_busy && n < 200) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
    endtask

    // Reset state: R1.
    task automatic t_reset();
        check(!link_req && !link_ack && !recv_strobe && !send_busy, "R1",
              {link_req, link_ack, recv_strobe, send_busy}, 0);
    endtask

    // One isolated transfer with full phase timing: R2, R4, R5, R6, R9.
    task automatic t_single(input logic [W-1:0] w);
        int n;
        int base = rx_n;
        pulse(w);
        check(send_busy, "R9 busy after go", send_busy, 1);
        n = 0;
        while (!link_req && n < 50) begin @(negedge clk); n++; end
        check(n == DLY, "R2 req delay", n, DLY);
        check(link_data == w, "R2 data with req", link_data, w);
        n = 0;
        while (!recv_strobe && n < 50) begin @(negedge clk); n++; end
        check(recv_word == w, "R4 captured word", recv_word, w);
        @(negedge clk);
        check(link_ack && !recv_strobe, "R4 ack one cycle after strobe",
              {link_ack, recv_strobe}, 2);
        n = 0;
        while (link_req && n < 50) begin @(negedge clk); n++; end
        check(n == 3, "R5 req fall after ack rise", n, 3);
        n = 0;
        while (link_ack && n < 50) begin @(negedge clk); n++; end
        check(n == 3, "R6 ack fall after req fall", n, 3);
        wait_idle();
        check(!send_busy && !link_req && !link_ack, "R9 idle after transfer",
              {send_busy, link_req, link_ack}, 0);
        check(rx_n == base + 1, "R10 single delivery count", rx_n - base, 1);
    endtask

    // Pulses during a transfer: R8 pending and latest-wins replacement.
    task automatic t_pending();
        int base = rx_n;
        pulse(8'hA1);
        repeat (3) @(negedge clk);
        pulse(8'hB2);
        pulse(8'hC3);
        wait_idle();
        check(rx_n == base + 2, "R8 two words delivered", rx_n - base, 2);
        check(rx[base] == 8'hA1, "R8 first word", rx[base], 8'hA1);
        check(rx[base+1] == 8'hC3, "R8 newer pending word wins", rx[base+1], 8'hC3);
    endtask

    // Pulse near the end of return-to-zero at several offsets: R10.
    task automatic t_boundary();
        for (int off = 0; off < 6; off++) begin
            int base = rx_n;
            int n = 0;
            pulse(8'h10 + 8'(off));
            while (!link_ack && n < 60) begin @(negedge clk); n++; end
            n = 0;
            while (link_ack && n < 60) begin @(negedge clk); n++; end
            repeat (off) @(negedge clk);
            pulse(8'h80 + 8'(off));
            wait_idle();
            check(rx_n == base + 2, "R10 both words delivered", rx_n - base, 2);
            check(rx[base] == 8'h10 + 8'(off) && rx[base+1] == 8'h80 + 8'(off),
                  "R10 order", rx[base+1], 8'h80 + off);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single(8'h5A);
        t_single(8'hFF);
        t_single(8'h00);
        t_pending();
        t_boundary();
        check(r3_bad == 0, "R3 data stable while req high", r3_bad, 0);
        check(r7_bad == 0, "R7 req rose with ack high", r7_bad, 0);
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule